// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates five interrupt requests for a small processor core: two external active-low pins, two timer overflow flags and one serial request (receive-done OR transmit-done). Each source has its own enable bit and its own priority bit, and a global enable gates all of them. Each external pin can be set to level mode or to falling-edge mode. On each machine-cycle strobe the controller picks the best pending source. It then pulses a request together with that source's fixed vector address, and in the same cycle it pulses a one-hot acknowledge.

Two nesting levels are tracked. A high-priority source can interrupt a running low-priority handler. A request at the same level or a lower level as the running handler waits until the return strobe releases that level. The controller clears the hardware flags that are meant to be cleared on acceptance: edge-captured external flags directly, and timer flags through a clear pulse sent back to the timer. The serial flags and level requests are left for software and the external circuit. Saving the program counter is the core's job.

Top module: `prio_irq_unit`

## Requirements
- R1: While reset is low and on the first cycle after it: irq_req = 0, irq_vec = 0000h, src_ack = 0, tmr_clr = 0, ext_flag = 0, lvl_act = 0.
- R2: Source index i is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. An accepted source i drives irq_vec = 0003h + 8*i, which gives 0003h, 000Bh, 0013h, 001Bh and 0023h. src_ack bit i pulses together with irq_req.
- R3: Among pending sources of the same priority, the lowest index wins.
- R4: src_hi bit i = 1 makes source i high priority. A high request is accepted while only the low level is active (lvl_act bit 0 = low, bit 1 = high). A request at the same level or a lower level than an active level is held off.
- R5: A source is pending only if its src_en bit and glob_en are both 1. Otherwise it never produces a request.
- R6: With ext_edge bit = 0, ext_flag follows the inverted pin as sampled on each strobe. Acceptance does not clear it, so a pin still low after the return strobe requests again.
- R7: With ext_edge bit = 1, ext_flag is set only when a strobe sample of 0 follows a strobe sample of 1. The first sample after reset counts as 0. The flag stays set until its source is accepted, which clears it.
- R8: tmr_clr bit k pulses in the same cycle as the acknowledge of timer k. The serial source is acknowledged but is never cleared, so it requests again after a return.
- R9: ret_stb clears the high level if it is active, and the low level otherwise.
- R10: Acceptance happens only on a clock edge where cyc_stb = 1. irq_req and src_ack are high for the single following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cyc_stb | input | 1 | machine-cycle sample and decision strobe |
| ret_stb | input | 1 | return-from-interrupt strobe |
| ext_n | input | N_EXT | external request pins, active low |
| ext_edge | input | N_EXT | 1 = falling-edge mode, 0 = level mode |
| tmr_flag | input | N_TMR | timer overflow flags |
| ser_ri | input | 1 | serial receive flag |
| ser_ti | input | 1 | serial transmit flag |
| glob_en | input | 1 | global interrupt enable |
| src_en | input | N_SRC | per-source enable |
| src_hi | input | N_SRC | per-source high-priority select |
| irq_req | output | 1 | one-cycle vector request |
| irq_vec | output | VEC_W | vector address of the last accepted source |
| src_ack | output | N_SRC | one-hot acknowledge pulse |
| tmr_clr | output | N_TMR | timer flag clear pulse |
| ext_flag | output | N_EXT | captured external request flags |
| lvl_act | output | 2 | active levels: bit 0 low, bit 1 high |

## Verification
The decision, the edge capture and the level update all happen on the strobe edge. irq_req, irq_vec, src_ack, tmr_clr, ext_flag and lvl_act are therefore due one clock after the edge where cyc_stb or ret_stb is seen. A pin change reaches a request only at the next strobe after it has been captured into ext_flag. The bench sets inputs 2 ns after a rising edge and advances a reference model by exactly one edge. It compares every output 2 ns after the following edge, so each comparison lands on the cycle in which the result is due.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt controller.
// Assumes source slots interleave external and timer inputs, with serial last.
package irq_pkg;
    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_id_e;

    // Vector address of a source slot.
    function automatic logic [31:0] vec_addr(input int base, input int step, input int idx);
        return 32'(base + step * idx);
    endfunction
endpackage

// File: rtl/irq_ext_trig.sv
// Capture logic for one external request pin (active low).
// Level mode: the flag mirrors the inverted pin on each strobe.
// Edge mode: the flag sets on a 1-then-0 pair of strobe samples and clears on acceptance.
// Assumes clr is raised only on a strobe cycle.
module irq_ext_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    logic samp_q;

    // Sample the pin once per machine cycle and update the request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            flag   <= 1'b0;
        end else if (stb) begin
            samp_q <= pin_n;
            if (!edge_mode)
                flag <= ~pin_n;
            else if (clr)
                flag <= 1'b0;
            else if (samp_q && !pin_n)
                flag <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational picker: takes the lowest-index pending source of the best
// level that may still be entered, given the levels already active.
module irq_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] hi,
    input  logic         act_hi,
    input  logic         act_lo,
    output logic [N-1:0] gnt,
    output logic         gnt_hi
);
    logic [N-1:0] hp, lp, sel;

    // Split the pending set by level and choose the level allowed to enter.
    always_comb begin
        hp  = pend & hi;
        lp  = pend & ~hi;
        sel = '0;
        if (!act_hi && (|hp))
            sel = hp;
        else if (!act_hi && !act_lo)
            sel = lp;
    end

    // Keep the lowest set index of the chosen level.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
        gnt_hi = |(gnt & hi);
    end
endmodule

// File: rtl/irq_level_track.sv
// Tracks the two nesting levels currently in service.
// A return strobe releases the highest active level; acceptance then marks its level.
module irq_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ret,
    input  logic       set_hi,
    input  logic       set_lo,
    output logic [1:0] act
);
    logic [1:0] nxt;

    // Apply the return first, then the new acceptance.
    always_comb begin
        nxt = act;
        if (ret) begin
            if (act[1]) nxt[1] = 1'b0;
            else        nxt[0] = 1'b0;
        end
        if (set_hi) nxt[1] = 1'b1;
        if (set_lo) nxt[0] = 1'b1;
    end

    // Hold the active-level state.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= 2'b00;
        else        act <= nxt;
    end
endmodule

// File: rtl/prio_irq_unit.sv
// Top of the two-level interrupt controller.
// Slot 2k holds external k, slot 2k+1 holds timer k, and the last slot is serial.
// Assumes N_EXT == N_TMR. Requests are accepted only on cyc_stb. The core is
// assumed to take every irq_req pulse.
module prio_irq_unit #(
    parameter int N_EXT    = 2,
    parameter int N_TMR    = 2,
    parameter int N_SRC    = N_EXT + N_TMR + 1,
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic             ret_stb,
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic [N_TMR-1:0] tmr_flag,
    input  logic             ser_ri,
    input  logic             ser_ti,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_hi,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [N_SRC-1:0] src_ack,
    output logic [N_TMR-1:0] tmr_clr,
    output logic [N_EXT-1:0] ext_flag,
    output logic [1:0]       lvl_act
);
    localparam int SER_IDX = N_SRC - 1;
    localparam int IDX_W   = $clog2(N_SRC);

    logic [N_SRC-1:0] raw, pend, gnt;
    logic             gnt_hi, take;
    logic [IDX_W-1:0] gnt_idx;

    // External pins sit in even slots.
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        irq_ext_trig u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (cyc_stb),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_edge[k]),
            .clr       (take && gnt[2*k]),
            .flag      (ext_flag[k])
        );
        assign raw[2*k] = ext_flag[k];
    end

    // Timer flags sit in odd slots.
    for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
        assign raw[2*k+1] = tmr_flag[k];
    end

    assign raw[SER_IDX] = ser_ri | ser_ti;
    assign pend         = raw & src_en & {N_SRC{glob_en}};

    irq_arbiter #(.N(N_SRC)) u_arb (
        .pend   (pend),
        .hi     (src_hi),
        .act_hi (lvl_act[1]),
        .act_lo (lvl_act[0]),
        .gnt    (gnt),
        .gnt_hi (gnt_hi)
    );

    assign take = cyc_stb && (|gnt);

    irq_level_track u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ret    (ret_stb),
        .set_hi (take && gnt_hi),
        .set_lo (take && !gnt_hi),
        .act    (lvl_act)
    );

    // Encode the one-hot grant into a slot number for the vector.
    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N_SRC; i++)
            if (gnt[i]) gnt_idx = IDX_W'(i);
    end

    // Register the request, vector, acknowledge and timer clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            src_ack <= '0;
            tmr_clr <= '0;
        end else begin
            irq_req <= take;
            src_ack <= take ? gnt : '0;
            for (int k = 0; k < N_TMR; k++)
                tmr_clr[k] <= take && gnt[2*k+1];
            if (take)
                irq_vec <= VEC_W'(irq_pkg::vec_addr(VEC_BASE, VEC_STEP, int'(gnt_idx)));
        end
    end
endmodule

// File: rtl/prio_irq_unit_chk.sv
// Protocol checker for prio_irq_unit, attached by bind.
module prio_irq_unit_chk #(
    parameter int N_TMR    = 2,
    parameter int N_SRC    = 5,
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_stb,
    input logic             ret_stb,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [N_SRC-1:0] src_ack,
    input logic [N_TMR-1:0] tmr_clr,
    input logic [1:0]       lvl_act
);
    // R10: a request only follows a strobe edge
    p_req_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(cyc_stb));

    // R2: acknowledge is one-hot exactly when a request is out
    p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack) && ((src_ack != '0) == irq_req));

    // R2: a vector lies on the slot grid
    p_vec_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0));

    // R4: nothing is accepted while the high level is active
    p_hi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(lvl_act[1]));

    // R4: an acceptance during a low handler must be high priority
    p_lo_nests_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(lvl_act[0])) |-> lvl_act[1]);

    // R9: a return releases an active high level
    p_ret_drops_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_stb) && $past(lvl_act[1])) |-> !lvl_act[1]);

    // R8: each timer clear pulse matches that timer's acknowledge
    for (genvar k = 0; k < N_TMR; k++) begin : g_tc
        p_tmr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_clr[k] == src_ack[2*k+1]);
    end
endmodule

bind prio_irq_unit prio_irq_unit_chk #(
    .N_TMR(N_TMR), .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ret_stb(ret_stb),
    .irq_req(irq_req), .irq_vec(irq_vec), .src_ack(src_ack),
    .tmr_clr(tmr_clr), .lvl_act(lvl_act)
);

// File: tb/prio_irq_unit_tb.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared each cycle against a reference model built from the requirements.
module prio_irq_unit_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cyc_stb, ret_stb, ser_ri, ser_ti, glob_en;
    logic [1:0] ext_n, ext_edge, tmr_flag, tmr_clr, ext_flag, lvl_act;
    logic [4:0] src_en, src_hi, src_ack;
    logic irq_req;
    logic [15:0] irq_vec;

    prio_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ret_stb(ret_stb),
        .ext_n(ext_n), .ext_edge(ext_edge), .tmr_flag(tmr_flag),
        .ser_ri(ser_ri), .ser_ti(ser_ti), .glob_en(glob_en),
        .src_en(src_en), .src_hi(src_hi), .irq_req(irq_req), .irq_vec(irq_vec),
        .src_ack(src_ack), .tmr_clr(tmr_clr), .ext_flag(ext_flag), .lvl_act(lvl_act)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [1:0]  m_samp, m_flag, m_act, e_tclr;
    logic        e_req;
    logic [4:0]  e_ack;
    logic [15:0] e_vec;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int first_set(logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        m_samp = 2'b00; m_flag = 2'b00; m_act = 2'b00;
        e_req = 1'b0; e_ack = 5'b0; e_vec = 16'h0000; e_tclr = 2'b00;
    endtask

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_step();
        logic [4:0] raw, pend, hp, lp;
        int g;
        raw  = {ser_ri | ser_ti, tmr_flag[1], m_flag[1], tmr_flag[0], m_flag[0]};
        pend = raw & src_en & {5{glob_en}};
        hp = pend & src_hi;
        lp = pend & ~src_hi;
        g = -1;
        if (cyc_stb) begin
            if (!m_act[1] && hp != 0)                  g = first_set(hp);
            else if (!m_act[1] && !m_act[0] && lp != 0) g = first_set(lp);
        end
        e_req  = (g >= 0);
        e_ack  = (g >= 0) ? 5'(1 << g) : 5'b0;
        e_tclr = {g == 3, g == 1};
        if (g >= 0) e_vec = 16'(3 + 8 * g);
        if (cyc_stb) begin
            for (int k = 0; k < 2; k++) begin
                if (!ext_edge[k])                   m_flag[k] = ~ext_n[k];
                else if (g == 2 * k)                m_flag[k] = 1'b0;
                else if (m_samp[k] && !ext_n[k])    m_flag[k] = 1'b1;
                m_samp[k] = ext_n[k];
            end
        end
        if (ret_stb) begin
            if (m_act[1]) m_act[1] = 1'b0;
            else          m_act[0] = 1'b0;
        end
        if (g >= 0) begin
            if (src_hi[g]) m_act[1] = 1'b1;
            else           m_act[0] = 1'b1;
        end
    endtask

    // One clock: model, edge, then compare 2 ns after the edge.
    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        #2;
        check({tag, " irq_req"},  32'(irq_req),  32'(e_req));
        check({tag, " irq_vec"},  32'(irq_vec),  32'(e_vec));
        check({tag, " src_ack"},  32'(src_ack),  32'(e_ack));
        check({tag, " tmr_clr"},  32'(tmr_clr),  32'(e_tclr));
        check({tag, " ext_flag"}, 32'(ext_flag), 32'(m_flag));
        check({tag, " lvl_act"},  32'(lvl_act),  32'(m_act));
    endtask

    task automatic quiet();
        cyc_stb = 0; ret_stb = 0; ext_n = 2'b11; ext_edge = 2'b00; tmr_flag = 2'b00;
        ser_ri = 0; ser_ti = 0; glob_en = 0; src_en = 5'b0; src_hi = 5'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        quiet();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs quiet during reset
        check("R1 reset irq_req", 32'(irq_req), 0);
        check("R1 reset irq_vec", 32'(irq_vec), 0);
        check("R1 reset lvl_act", 32'(lvl_act), 0);
        rst_n = 1;
        tick("R1 after reset");

        // R3 + R2: timers and serial together, timer 0 wins, vector 000Bh
        glob_en = 1; src_en = 5'h1F; cyc_stb = 1; tmr_flag = 2'b11; ser_ri = 1;
        tick("R3 tie-break");
        check("R2 vector timer0", 32'(irq_vec), 32'h000B);
        cyc_stb = 0; ret_stb = 1; tmr_flag = 2'b10;
        tick("R9 return low");
        ret_stb = 0; cyc_stb = 1;
        tick("R8 timer1 clear");
        check("R2 vector timer1", 32'(irq_vec), 32'h001B);
        cyc_stb = 0; ret_stb = 1; tmr_flag = 2'b00;
        tick("R9 return");
        ret_stb = 0; cyc_stb = 1;
        tick("R8 serial no clear");
        check("R2 vector serial", 32'(irq_vec), 32'h0023);
        cyc_stb = 0; ret_stb = 1;
        tick("R9 return serial");
        ret_stb = 0; cyc_stb = 1;
        tick("R8 serial retriggers");
        ret_stb = 1; cyc_stb = 0; ser_ri = 0;
        tick("R9 return");
        ret_stb = 0;

        // R4 + R6: low ext0 level request, then high ext1 preempts
        src_hi = 5'b00100; ext_n = 2'b10; cyc_stb = 1;
        tick("R6 level capture");
        tick("R6 low accept");
        ext_n = 2'b00;
        tick("R4 same level waits");
        tick("R4 high preempts");
        tick("R4 all blocked");
        cyc_stb = 0; ret_stb = 1;
        tick("R9 drop high");
        ret_stb = 0; cyc_stb = 1;
        tick("R6 level retrigger");
        ext_n = 2'b11; cyc_stb = 0; ret_stb = 1;
        tick("R9 drop high");
        tick("R9 drop low");
        ret_stb = 0; cyc_stb = 1;
        tick("R6 level released");

        // R5: masking
        glob_en = 0; tmr_flag = 2'b01;
        tick("R5 global mask");
        tick("R5 global mask");
        glob_en = 1; src_en = 5'b11101;
        tick("R5 source mask");
        tmr_flag = 2'b00; src_en = 5'h1F;
        tick("R5 idle");

        // R7: edge mode, pin held low after reset-like sequence
        ext_edge = 2'b11; src_hi = 5'b0;
        tick("R7 high sample");
        ext_n = 2'b01; cyc_stb = 0;
        tick("R10 no strobe");
        cyc_stb = 1;
        tick("R7 fall captured");
        tick("R7 accept clears");
        cyc_stb = 0; ret_stb = 1;
        tick("R9 return");
        ret_stb = 0; cyc_stb = 1;
        tick("R7 held low no retrigger");
        tick("R7 held low no retrigger");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            cyc_stb = ($urandom % 2) == 0;
            ret_stb = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) ext_n[$urandom % 2] ^= 1'b1;
            if (($urandom % 32) == 0) ext_edge = 2'($urandom);
            for (int k = 0; k < 2; k++) begin
                if (tmr_clr[k]) tmr_flag[k] = 1'b0;
                else if (($urandom % 10) == 0) tmr_flag[k] = 1'b1;
            end
            if (($urandom % 12) == 0) ser_ri = ~ser_ri;
            if (($urandom % 12) == 0) ser_ti = ~ser_ti;
            if (($urandom % 40) == 0) glob_en = ~glob_en;
            if (($urandom % 40) == 0) src_en = 5'($urandom);
            if (($urandom % 30) == 0) src_hi = 5'($urandom);
            tick("R3 R4 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule